// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit Execution Unit

This unit executes the second page of an 8-bit processor's instruction set: the instructions reached after a prefix byte. It receives the byte that follows the prefix (the sub-opcode), the current flags and the HL pointer. From these it produces a rotated, shifted, nibble-swapped, bit-set or bit-cleared byte, or the result of a bit test. It also returns the updated flags and the number of machine cycles the instruction is charged. The three low bits of the sub-opcode pick one of eight operand slots. Seven slots are registers, read through a combinational register-file read port. The eighth is the byte in memory at HL, which the unit reads, modifies and writes back through a simple byte memory port.

The request arrives on a valid/ready stream and the result leaves on a valid/ready stream. The unit holds one instruction at a time. `in_ready` is high only when the unit is empty, and a request transfers on a cycle with both `in_valid` and `in_ready` high. A result is offered with `out_valid` and stays unchanged until a cycle with `out_ready` high, so the consumer can stall it for any length of time. The register read port is sampled in the accept cycle. The memory read request is held, with its address, until `mem_rd_valid` answers it. The write-back is a single-cycle strobe.

Flags travel as a 4-bit nibble: bit 3 Z (zero), bit 2 N (subtract), bit 1 H (half carry), bit 0 C (carry).

Top module: `pbu_top`

## Requirements
- R1: Sub-opcode bits 2:0 select the operand: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory at HL, 7 A. For a register slot, `rf_rd_idx` equals those bits in the accept cycle. Register results are returned with `out_reg_idx` set to that slot and `out_wr_reg` high; memory-slot results never assert `out_wr_reg`.
- R2: Sub-opcodes 0x00-0x07 rotate left circularly: old bit 7 goes to bit 0 and to C. Sub-opcodes 0x08-0x0F rotate right circularly: old bit 0 goes to bit 7 and to C.
- R3: 0x10-0x17 rotate left through carry: the old C enters bit 0 and old bit 7 becomes C. 0x18-0x1F rotate right through carry: the old C enters bit 7 and old bit 0 becomes C.
- R4: 0x20-0x27 shift left with bit 0 filled by zero and old bit 7 to C. 0x28-0x2F shift right keeping bit 7 unchanged, with old bit 0 to C. 0x38-0x3F shift right with bit 7 filled by zero, with old bit 0 to C.
- R5: 0x30-0x37 exchange the two nibbles of the operand; C is cleared.
- R6: Every rotate, shift and swap clears N and H and sets Z exactly when the 8-bit result is zero.
- R7: 0x40-0x7F test the bit whose index is sub-opcode bits 5:3. Z is set when that bit is 0 and cleared when it is 1, H is set, N is cleared and C keeps its input value. Nothing is written back: `out_wr_reg` stays low, and on the memory slot no memory write occurs.
- R8: 0x80-0xBF clear and 0xC0-0xFF set the bit indexed by bits 5:3, leaving all other bits unchanged; all four flags are returned exactly as given.
- R9: On the memory slot the unit raises `mem_rd_req` with `mem_addr` equal to the accepted HL and holds both until `mem_rd_valid`. For every operation except the bit test it then issues exactly one single-cycle write of the result to the same address.
- R10: `out_cycles` is 2 for any register operand, 4 for rotate, shift, swap, set and clear on memory, and 3 for a bit test on memory.
- R11: `in_ready` is low from acceptance until the result has been taken. While `out_valid` is high and `out_ready` is low, the result, flags and cycle count stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit empty and able to accept |
| in_op | input | 8 | Sub-opcode following the prefix |
| in_flags | input | 4 | Flags before the instruction (Z,N,H,C) |
| in_hl | input | ADDR_W | HL pointer for the memory slot |
| rf_rd_idx | output | 3 | Register read slot |
| rf_rd_data | input | 8 | Register read data, combinational |
| mem_rd_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | ADDR_W | Memory address for read and write |
| mem_rd_valid | input | 1 | Memory read data valid |
| mem_rd_data | input | 8 | Memory read data |
| mem_wr_en | output | 1 | Single-cycle memory write strobe |
| mem_wr_data | output | 8 | Memory write data |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 8 | Computed byte (operand value for a bit test) |
| out_flags | output | 4 | Flags after the instruction (Z,N,H,C) |
| out_wr_reg | output | 1 | Result must be written to the register slot |
| out_reg_idx | output | 3 | Register slot to write |
| out_cycles | output | CYC_W | Machine cycles charged |

## Verification
The bench drives operand values with both end bits set, so a rotate that loses bit 0 or bit 7, or a through-carry rotate that ignores the incoming C, gives a visibly wrong byte or carry. Zero-producing operands check that Z follows the 8-bit result and not a wider sum. The bit tests sweep every index on both a set and a cleared bit, so a swapped polarity or an index taken from the wrong field fails. A memory bit test that writes back, or a memory operation charged a register cost, shows up in the write count and in `out_cycles`. The bench also holds `out_ready` low for several cycles to catch a result that changes or a unit that accepts a second request while stalled.

// File: rtl/pbu_pkg.sv
package pbu_pkg;

  typedef enum logic [3:0] {
    K_RLC, K_RRC, K_RL, K_RR, K_SLA, K_SRA, K_SWAP, K_SRL,
    K_TEST, K_CLR, K_SET
  } pbu_kind_t;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } pbu_flags_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_RD, ST_WR, ST_DONE
  } pbu_state_t;

  localparam logic [2:0] MEM_SLOT = 3'd6;

endpackage

// File: rtl/pbu_decode.sv
module pbu_decode
  import pbu_pkg::*;
(
  input  logic [7:0] op,
  output pbu_kind_t  kind,
  output logic [2:0] bit_idx,
  output logic       is_mem,
  output logic       is_test
);
  always_comb begin
    unique case (op[7:6])
      2'b00: kind = pbu_kind_t'({1'b0, op[5:3]});
      2'b01: kind = K_TEST;
      2'b10: kind = K_CLR;
      default: kind = K_SET;
    endcase
  end

  assign bit_idx = op[5:3];
  assign is_mem  = (op[2:0] == MEM_SLOT);
  assign is_test = (op[7:6] == 2'b01);
endmodule

// File: rtl/pbu_alu.sv
module pbu_alu
  import pbu_pkg::*;
(
  input  pbu_kind_t  kind,
  input  logic [2:0] bit_idx,
  input  logic [7:0] val,
  input  pbu_flags_t fin,
  output logic [7:0] res,
  output pbu_flags_t fout
);
  logic [7:0] mask;
  logic [7:0] sh;
  logic       sh_c;

  always_comb begin
    mask = '0;
    mask[bit_idx] = 1'b1;
  end

  always_comb begin
    sh   = val;
    sh_c = 1'b0;
    unique case (kind)
      K_RLC:  begin sh = {val[6:0], val[7]}; sh_c = val[7]; end
      K_RRC:  begin sh = {val[0], val[7:1]}; sh_c = val[0]; end
      K_RL:   begin sh = {val[6:0], fin.c};  sh_c = val[7]; end
      K_RR:   begin sh = {fin.c, val[7:1]};  sh_c = val[0]; end
      K_SLA:  begin sh = {val[6:0], 1'b0};   sh_c = val[7]; end
      K_SRA:  begin sh = {val[7], val[7:1]}; sh_c = val[0]; end
      K_SWAP: begin sh = {val[3:0], val[7:4]}; sh_c = 1'b0; end
      K_SRL:  begin sh = {1'b0, val[7:1]};   sh_c = val[0]; end
      default: begin sh = val; sh_c = 1'b0; end
    endcase
  end

  always_comb begin
    res  = val;
    fout = fin;
    unique case (kind)
      K_TEST: begin
        res    = val;
        fout.z = ((val & mask) == 8'h00);
        fout.n = 1'b0;
        fout.h = 1'b1;
        fout.c = fin.c;
      end
      K_CLR: res = val & ~mask;
      K_SET: res = val | mask;
      default: begin
        res    = sh;
        fout.z = (sh == 8'h00);
        fout.n = 1'b0;
        fout.h = 1'b0;
        fout.c = sh_c;
      end
    endcase
  end
endmodule

// File: rtl/pbu_seq.sv
module pbu_seq
  import pbu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic is_mem,
  input  logic is_test,
  input  logic mem_rd_valid,
  input  logic out_ready,
  output logic idle,
  output logic st_rd,
  output logic st_wr,
  output logic st_done
);
  pbu_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (in_valid) st_nx = is_mem ? ST_RD : ST_DONE;
      ST_RD:   if (mem_rd_valid) st_nx = is_test ? ST_DONE : ST_WR;
      ST_WR:   st_nx = ST_DONE;
      default: if (out_ready) st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign idle    = (st == ST_IDLE);
  assign st_rd   = (st == ST_RD);
  assign st_wr   = (st == ST_WR);
  assign st_done = (st == ST_DONE);
endmodule

// File: rtl/pbu_top.sv
module pbu_top
  import pbu_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int CYC_W        = 3,
  parameter int REG_CYC      = 2,
  parameter int MEM_CYC      = 4,
  parameter int MEM_TEST_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_op,
  input  logic [3:0]        in_flags,
  input  logic [ADDR_W-1:0] in_hl,
  output logic [2:0]        rf_rd_idx,
  input  logic [7:0]        rf_rd_data,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rd_valid,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_en,
  output logic [7:0]        mem_wr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_result,
  output logic [3:0]        out_flags,
  output logic              out_wr_reg,
  output logic [2:0]        out_reg_idx,
  output logic [CYC_W-1:0]  out_cycles
);
  localparam logic [CYC_W-1:0] C_REG  = CYC_W'(REG_CYC);
  localparam logic [CYC_W-1:0] C_MEM  = CYC_W'(MEM_CYC);
  localparam logic [CYC_W-1:0] C_MTST = CYC_W'(MEM_TEST_CYC);

  logic [7:0]        op_q;
  pbu_flags_t        flg_q;
  logic [ADDR_W-1:0] hl_q;
  logic [7:0]        res_q;
  pbu_flags_t        fout_q;
  logic [CYC_W-1:0]  cyc_q;

  logic              idle, st_rd, st_wr, st_done;
  logic [7:0]        op_sel;
  pbu_flags_t        flg_sel;
  logic [7:0]        operand;
  pbu_kind_t         kind;
  logic [2:0]        bit_idx;
  logic              is_mem, is_test;
  logic [7:0]        alu_res;
  pbu_flags_t        alu_flg;
  logic              accept, mem_load;

  // One decoder and one ALU are shared: the new request while idle,
  // the held request while the memory read is outstanding.
  assign op_sel  = idle ? in_op : op_q;
  assign flg_sel = idle ? pbu_flags_t'(in_flags) : flg_q;
  assign operand = idle ? rf_rd_data : mem_rd_data;

  pbu_decode u_dec (
    .op(op_sel), .kind(kind), .bit_idx(bit_idx),
    .is_mem(is_mem), .is_test(is_test)
  );

  pbu_alu u_alu (
    .kind(kind), .bit_idx(bit_idx), .val(operand), .fin(flg_sel),
    .res(alu_res), .fout(alu_flg)
  );

  pbu_seq u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .is_mem(is_mem), .is_test(is_test),
    .mem_rd_valid(mem_rd_valid), .out_ready(out_ready),
    .idle(idle), .st_rd(st_rd), .st_wr(st_wr), .st_done(st_done)
  );

  assign accept   = in_valid & idle;
  assign mem_load = st_rd & mem_rd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= '0;
      flg_q  <= '0;
      hl_q   <= '0;
      res_q  <= '0;
      fout_q <= '0;
      cyc_q  <= '0;
    end else begin
      if (accept) begin
        op_q  <= in_op;
        flg_q <= pbu_flags_t'(in_flags);
        hl_q  <= in_hl;
        cyc_q <= is_mem ? (is_test ? C_MTST : C_MEM) : C_REG;
      end
      if ((accept && !is_mem) || mem_load) begin
        res_q  <= alu_res;
        fout_q <= alu_flg;
      end
    end
  end

  assign in_ready    = idle;
  assign rf_rd_idx   = in_op[2:0];
  assign mem_rd_req  = st_rd;
  assign mem_addr    = hl_q;
  assign mem_wr_en   = st_wr;
  assign mem_wr_data = res_q;
  assign out_valid   = st_done;
  assign out_result  = res_q;
  assign out_flags   = fout_q;
  assign out_wr_reg  = st_done & ~is_mem & ~is_test;
  assign out_reg_idx = op_q[2:0];
  assign out_cycles  = cyc_q;
endmodule

// File: rtl/pbu_chk.sv
module pbu_chk #(
  parameter int ADDR_W       = 16,
  parameter int CYC_W        = 3,
  parameter int REG_CYC      = 2,
  parameter int MEM_CYC      = 4,
  parameter int MEM_TEST_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [7:0]        in_op,
  input logic [ADDR_W-1:0] in_hl,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_valid,
  input logic              mem_wr_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_result,
  input logic [3:0]        out_flags,
  input logic              out_wr_reg,
  input logic [2:0]        out_reg_idx,
  input logic [CYC_W-1:0]  out_cycles
);
  logic [7:0]        op_seen;
  logic [ADDR_W-1:0] hl_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_seen <= '0;
      hl_seen <= '0;
    end else if (in_valid && in_ready) begin
      op_seen <= in_op;
      hl_seen <= in_hl;
    end
  end

  assert_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wr_reg) |-> (out_reg_idx != 3'd6 && op_seen[2:0] != 3'd6));

  assert_test_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (op_seen[7:6] != 2'b01));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_addr)));

  assert_rd_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req || mem_wr_en) |-> (mem_addr == hl_seen));

  assert_single_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> !mem_wr_en);

  assert_cycles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cycles == ((op_seen[2:0] != 3'd6) ? CYC_W'(REG_CYC) :
                   ((op_seen[7:6] == 2'b01) ? CYC_W'(MEM_TEST_CYC) : CYC_W'(MEM_CYC)))));

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
                                   $stable(out_flags) && $stable(out_cycles)));
endmodule

bind pbu_top pbu_chk #(
  .ADDR_W(ADDR_W), .CYC_W(CYC_W), .REG_CYC(REG_CYC),
  .MEM_CYC(MEM_CYC), .MEM_TEST_CYC(MEM_TEST_CYC)
) u_chk (.*);

// File: tb/sim_pbu_top.sv
`timescale 1ns/1ps
module sim_pbu_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_op;
  logic [3:0]  in_flags;
  logic [15:0] in_hl;
  logic [2:0]  rf_rd_idx;
  logic [7:0]  rf_rd_data;
  logic        mem_rd_req;
  logic [15:0] mem_addr;
  logic        mem_rd_valid;
  logic [7:0]  mem_rd_data;
  logic        mem_wr_en;
  logic [7:0]  mem_wr_data;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_result;
  logic [3:0]  out_flags;
  logic        out_wr_reg;
  logic [2:0]  out_reg_idx;
  logic [2:0]  out_cycles;

  int n_tests = 0;
  int n_fail  = 0;
  int wr_count = 0;
  logic [7:0] rf  [0:7];
  logic [7:0] mem [0:255];

  always #2.5 clk = ~clk;

  pbu_top u0 (.*);

  assign rf_rd_data = rf[rf_rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_rd_valid <= 1'b0;
      mem_rd_data  <= 8'h00;
    end else begin
      mem_rd_valid <= mem_rd_req && !mem_rd_valid;
      mem_rd_data  <= mem[mem_addr[7:0]];
      if (mem_wr_en) begin
        mem[mem_addr[7:0]] <= mem_wr_data;
        wr_count <= wr_count + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Independent model: returns {result, Z, N, H, C}
  function automatic logic [11:0] model(input logic [7:0] op, input logic [7:0] v,
                                        input logic [3:0] f);
    logic [7:0] r;
    logic z, n, h, c;
    int b;
    b = int'(op[5:3]);
    r = v; z = f[3]; n = f[2]; h = f[1]; c = f[0];
    if (op < 8'h40) begin
      case (op[5:3])
        3'd0: begin r = (v << 1) | (v >> 7); c = v[7]; end
        3'd1: begin r = (v >> 1) | (v << 7); c = v[0]; end
        3'd2: begin r = (v << 1) | {7'd0, f[0]}; c = v[7]; end
        3'd3: begin r = (v >> 1) | {f[0], 7'd0}; c = v[0]; end
        3'd4: begin r = v << 1; c = v[7]; end
        3'd5: begin r = (v >> 1) | (v & 8'h80); c = v[0]; end
        3'd6: begin r = (v << 4) | (v >> 4); c = 1'b0; end
        default: begin r = v >> 1; c = v[0]; end
      endcase
      z = (r == 0); n = 0; h = 0;
    end else if (op < 8'h80) begin
      z = (v[b] == 1'b0); n = 0; h = 1;
    end else if (op < 8'hC0) begin
      r = v; r[b] = 1'b0;
    end else begin
      r = v; r[b] = 1'b1;
    end
    return {r, z, n, h, c};
  endfunction

  task automatic run_op(input logic [7:0] op, input logic [7:0] val,
                        input logic [3:0] fin, input logic [7:0] addr,
                        input string tag);
    logic [11:0] exp;
    bit mem_op, test_op;
    int wr0, exp_cyc, waitc;
    mem_op  = (op[2:0] == 3'd6);
    test_op = (op[7:6] == 2'b01);
    exp     = model(op, val, fin);
    if (mem_op) mem[addr] = val; else rf[op[2:0]] = val;
    wr0 = wr_count;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_flags = fin; in_hl = {8'hC0, addr};
    if (!mem_op)
      check(rf_rd_idx == op[2:0], "R1", "rf_rd_idx", rf_rd_idx, op[2:0]);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    waitc = 0;
    while (!out_valid && waitc < 20) begin
      @(negedge clk);
      waitc++;
    end
    check(out_valid, tag, "out_valid", out_valid, 1);
    check(out_result == exp[11:4], tag, $sformatf("result op %02h", op), out_result, exp[11:4]);
    check(out_flags == exp[3:0], tag, $sformatf("flags op %02h", op), out_flags, exp[3:0]);
    exp_cyc = mem_op ? (test_op ? 3 : 4) : 2;
    check(out_cycles == exp_cyc, "R10", $sformatf("cycles op %02h", op), out_cycles, exp_cyc);
    check(out_wr_reg == (!mem_op && !test_op), "R1", "out_wr_reg", out_wr_reg, !mem_op && !test_op);
    if (!mem_op && !test_op)
      check(out_reg_idx == op[2:0], "R1", "out_reg_idx", out_reg_idx, op[2:0]);
    check(!in_ready, "R11", "in_ready while busy", in_ready, 0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check(wr_count - wr0 == ((mem_op && !test_op) ? 1 : 0), mem_op ? "R9" : "R7",
          "write count", wr_count - wr0, (mem_op && !test_op) ? 1 : 0);
    if (mem_op)
      check(mem[addr] == (test_op ? val : exp[11:4]), "R9", "memory byte",
            mem[addr], test_op ? val : exp[11:4]);
    check(in_ready && !out_valid, "R11", "idle after take", {in_ready, out_valid}, 2);
  endtask

  task automatic t_reset();
    check(in_ready == 1'b1, "R11", "reset in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R11", "reset out_valid", out_valid, 0);
    check(mem_rd_req == 1'b0 && mem_wr_en == 1'b0, "R9", "reset mem strobes",
          {mem_rd_req, mem_wr_en}, 0);
  endtask

  task automatic t_slots();
    for (int s = 0; s < 8; s++) run_op(8'h00 | s[7:0], 8'h81 + s[7:0], 4'h0, 8'h10, "R1");
  endtask

  task automatic t_circular();
    run_op(8'h00, 8'h81, 4'h0, 8'h00, "R2");
    run_op(8'h07, 8'h40, 4'h1, 8'h00, "R2");
    run_op(8'h09, 8'h81, 4'h0, 8'h00, "R2");
    run_op(8'h0F, 8'h02, 4'h1, 8'h00, "R2");
  endtask

  task automatic t_through_carry();
    run_op(8'h10, 8'h80, 4'h1, 8'h00, "R3");
    run_op(8'h11, 8'h80, 4'h0, 8'h00, "R3");
    run_op(8'h1A, 8'h01, 4'h1, 8'h00, "R3");
    run_op(8'h1B, 8'h01, 4'h0, 8'h00, "R3");
  endtask

  task automatic t_shifts();
    run_op(8'h20, 8'hC1, 4'h1, 8'h00, "R4");
    run_op(8'h29, 8'h81, 4'h0, 8'h00, "R4");
    run_op(8'h2A, 8'h7E, 4'h1, 8'h00, "R4");
    run_op(8'h3B, 8'h81, 4'h0, 8'h00, "R4");
  endtask

  task automatic t_swap();
    run_op(8'h30, 8'hA5, 4'h1, 8'h00, "R5");
    run_op(8'h37, 8'h0F, 4'hF, 8'h00, "R5");
  endtask

  task automatic t_zero_flags();
    run_op(8'h38, 8'h01, 4'h6, 8'h00, "R6");
    run_op(8'h21, 8'h80, 4'h6, 8'h00, "R6");
    run_op(8'h32, 8'h00, 4'h7, 8'h00, "R6");
    run_op(8'h12, 8'h80, 4'h6, 8'h00, "R6");
  endtask

  task automatic t_bit_test();
    for (int b = 0; b < 8; b++) begin
      run_op(8'h40 | (b[7:0] << 3) | 8'h03, 8'h01 << b, 4'h5, 8'h00, "R7");
      run_op(8'h40 | (b[7:0] << 3) | 8'h07, ~(8'h01 << b), 4'hA, 8'h00, "R7");
    end
  endtask

  task automatic t_set_clear();
    for (int b = 0; b < 8; b++) begin
      run_op(8'h80 | (b[7:0] << 3) | 8'h01, 8'hFF, 4'h9, 8'h00, "R8");
      run_op(8'hC0 | (b[7:0] << 3) | 8'h04, 8'h00, 4'h6, 8'h00, "R8");
    end
  endtask

  task automatic t_memory();
    run_op(8'h06, 8'h81, 4'h0, 8'h21, "R9");
    run_op(8'h1E, 8'h01, 4'h1, 8'h22, "R9");
    run_op(8'h36, 8'h3C, 4'h0, 8'h23, "R9");
    run_op(8'h46, 8'h01, 4'h0, 8'h24, "R9");
    run_op(8'h7E, 8'h7F, 4'h1, 8'h25, "R9");
    run_op(8'hBE, 8'hFF, 4'h0, 8'h26, "R9");
    run_op(8'hC6, 8'h00, 4'hF, 8'h27, "R9");
  endtask

  task automatic t_backpressure();
    logic [7:0] r0;
    rf[2] = 8'h55;
    @(negedge clk);
    in_valid = 1'b1; in_op = 8'h02; in_flags = 4'h0; in_hl = 16'h0;
    @(posedge clk);
    @(negedge clk);
    in_op = 8'h03;
    r0 = out_result;
    check(out_valid, "R11", "result offered", out_valid, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(out_valid && out_result == r0, "R11", "held result", out_result, r0);
      check(!in_ready, "R11", "no accept while stalled", in_ready, 0);
    end
    check(r0 == 8'hAA, "R11", "stalled value", r0, 8'hAA);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check(in_ready && !out_valid, "R11", "released", {in_ready, out_valid}, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 8; i++) rf[i] = 8'h00;
    rst_n = 1'b0; in_valid = 1'b0; in_op = 8'h00; in_flags = 4'h0;
    in_hl = 16'h0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_slots();
    t_circular();
    t_through_carry();
    t_shifts();
    t_swap();
    t_zero_flags();
    t_bit_test();
    t_set_clear();
    t_memory();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule